// File: doc/BRIEF.md
# Address Translation Cache with Per-Page Access Checks

This block is a small, fully associative cache of address translations. A lookup presents a 32-bit logical address, an access type (read, write or read-modify-write) and a supervisor/user flag. The logical page number and the privilege flag together form the tag, and all entries are compared in parallel. One cycle later the block returns a hit or miss, the physical address, and the outcome of the access checks. Pages are fixed at 4 KB.

Each entry has four status bits beside its 24-bit physical page field. The bus-error bit makes every hit fault. The write-protect bit faults writes and read-modify-writes. The cache-inhibit bit drives the inhibit output for a completed access. A write to a page whose modified bit is still clear is stopped: the entry is dropped, and a re-walk is requested so the page descriptor gets its modified bit before the write is retried.

An external walker fills entries. A fill whose tag is already present replaces that entry in place, which serves as the load command. Flush-all and single-page invalidate clear entries. On a miss, the walker walks the tables, fills the entry, and retries the access. A fault recorded during the walk is therefore reported on the retry, not on the original miss.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, all response outputs are 0, and the first lookup of any address misses.
- R2: A lookup in cycle t gives rsp_valid=1 in cycle t+1. rsp_hit is 1 only when a valid entry's tag equals {lk_super, lk_addr[31:12]}, so the same page under the other privilege misses. When no lookup was made, rsp_valid is 0.
- R3: On a hit, rsp_paddr is {ppn[23:0], lk_addr[11:0]} truncated to its low 32 bits. On a miss it is 0.
- R4: Entry field layout is bit 27 bus-error, 26 cache-inhibit, 25 write-protect, 24 modified, 23:0 ppn. A hit on an entry whose bus-error bit is set raises rsp_fault for every access type and never raises rsp_rewalk.
- R5: Access type encoding is 00 read, 01 write, 10 read-modify-write, 11 treated as read. A write or read-modify-write that hits a write-protected entry (without bus-error) raises rsp_fault. A read of that entry completes normally.
- R6: A write or read-modify-write that hits an entry with bus-error and write-protect clear and modified clear raises rsp_rewalk, not rsp_fault, and invalidates the entry at the same edge, so the next lookup of that page misses.
- R7: rsp_inhibit is 1 exactly when the access hits an entry with cache-inhibit set and neither rsp_fault nor rsp_rewalk is raised.
- R8: A fill whose tag matches a valid entry overwrites that entry's status and page field and uses no new slot.
- R9: A fill with a new tag goes to the lowest-numbered invalid slot. When every slot is valid, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset, advances by one on each such replacement, and wraps after slot 21.
- R10: flush_all invalidates every entry in one cycle. pg_inval invalidates only the entry whose tag equals {pg_super, pg_lpn}.
- R11: When commands arrive in the same cycle, flush_all outranks pg_inval, which outranks a fill; the losing fill is dropped. A lookup in that cycle sees the contents before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address of the lookup |
| lk_kind | input | 2 | Access type: 00 read, 01 write, 10 read-modify-write |
| lk_super | input | 1 | Supervisor flag of the lookup |
| fl_valid | input | 1 | Fill request from the walker |
| fl_lpn | input | 20 | Logical page number being filled |
| fl_super | input | 1 | Privilege flag of the filled entry |
| fl_pte | input | 28 | Status bits and physical page of the filled entry |
| pg_inval | input | 1 | Invalidate a single page |
| pg_lpn | input | 20 | Page number to invalidate |
| pg_super | input | 1 | Privilege flag of the page to invalidate |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address |
| rsp_inhibit | output | 1 | Cache inhibit for this access |
| rsp_fault | output | 1 | Access must take a bus error |
| rsp_rewalk | output | 1 | Write aborted; walk again to set modified |

## Verification
Two situations are hard to reach from the ports. The first is the round-robin victim choice: it only matters once all 22 slots are full and an invalidate has opened a hole. The stimulus fills 22 distinct pages, adds more to force evictions, and then invalidates one slot to show that the free slot is taken before the pointer's slot. The second is the first-write abort. It needs an entry loaded with modified clear, a write that drops it, and a refill with modified set before the retried write succeeds. The directed sequence covers this path, and a long random mix over an 80-tag pool repeats it against a bench model of the entries and pointer.

// File: rtl/xc_pkg.sv
package xc_pkg;
    // Physical page field width held per entry
    localparam int unsigned XC_PPN_W = 24;

    // Access type encoding seen on lk_kind
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_RMW   = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    // Per-entry payload; bit order is fixed by the walker interface
    typedef struct packed {
        logic                bus_err;
        logic                inhibit;
        logic                wprot;
        logic                modified;
        logic [XC_PPN_W-1:0] ppn;
    } pte_t;

    localparam int unsigned XC_PTE_W = $bits(pte_t);
endpackage

// File: rtl/xc_oh_enc.sv
// One-hot to binary index encoder.
// Assumes at most one bit of oh is set; any reports a non-empty vector.
module xc_oh_enc #(
    parameter int unsigned N = 22,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] oh,
    output logic [W-1:0] idx,
    output logic         any
);
    // Turn the set bit position into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (oh[i]) idx = W'(i);
        end
    end

    // Flag that some bit is set
    assign any = |oh;
endmodule

// File: rtl/xc_victim.sv
// Slot chooser for new fills.
// Prefers the lowest invalid slot; otherwise uses a round-robin pointer that
// advances only when a valid slot is replaced. Assumes alloc is high only for
// fills that take a new slot.
module xc_victim #(
    parameter int unsigned ENTRIES = 22,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   vic_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;

    // Find the lowest-numbered invalid slot
    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
        end
    end

    // Pick a free slot if one exists, else the pointer's slot
    assign vic_idx = have_free ? free_idx : ptr_q;

    // Step the pointer on each replacement of a valid slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (alloc && !have_free) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < IDX_W'(ENTRIES));

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !have_free) |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/xc_tag_store.sv
// Entry storage with two parallel tag comparators.
// One comparator serves lookups and the other serves fills and invalidates.
// Write priority per entry: kill_all, kill_sel on match, write, drop.
// Assumes the caller never writes a tag already held in another slot.
module xc_tag_store
    import xc_pkg::*;
#(
    parameter int unsigned ENTRIES = 22,
    parameter int unsigned TAG_W   = 21,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic [TAG_W-1:0]   maint_tag,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  pte_t               wr_data,
    input  logic               drop_en,
    input  logic [IDX_W-1:0]   drop_idx,
    input  logic               kill_all,
    input  logic               kill_sel,
    output logic [ENTRIES-1:0] look_match,
    output logic [ENTRIES-1:0] maint_match,
    output logic [ENTRIES-1:0] valid_vec,
    output pte_t               look_data
);
    pte_t ent_data [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             vld_q;
        logic [TAG_W-1:0] tag_q;
        pte_t             dat_q;

        assign look_match[g]  = vld_q && (tag_q == look_tag);
        assign maint_match[g] = vld_q && (tag_q == maint_tag);
        assign valid_vec[g]   = vld_q;
        assign ent_data[g]    = dat_q;

        // Update one entry according to the command priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                tag_q <= '0;
                dat_q <= '0;
            end else if (kill_all) begin
                vld_q <= 1'b0;
            end else if (kill_sel && maint_match[g]) begin
                vld_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                vld_q <= 1'b1;
                tag_q <= maint_tag;
                dat_q <= wr_data;
            end else if (drop_en && (drop_idx == IDX_W'(g))) begin
                vld_q <= 1'b0;
            end
        end
    end

    // Gather the payload of the matching entry
    always_comb begin
        look_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) look_data = look_data | ent_data[i];
        end
    end

    // R8
    uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_match));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all |=> (valid_vec == '0));
endmodule

// File: rtl/xc_access_chk.sv
// Per-access status evaluation and registered response.
// Applies bus-error, then write-protect, then modified-clear checks to the
// hit entry and forms the physical address. Requests invalidation of the hit
// entry when a write needs a re-walk. Assumes hit is already qualified by req.
module xc_access_chk
    import xc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        kind,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              hit,
    input  pte_t              ent,
    output logic              drop_now,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_inhibit,
    output logic              rsp_fault,
    output logic              rsp_rewalk
);
    logic              is_wr;
    logic              fault_now;
    logic              rewalk_now;
    logic              inh_now;
    logic [ADDR_W-1:0] pa_now;

    // Classify the access as one that modifies memory
    assign is_wr = (kind == ACC_WRITE) || (kind == ACC_RMW);

    // Evaluate the status checks in priority order
    always_comb begin
        fault_now  = 1'b0;
        rewalk_now = 1'b0;
        if (hit) begin
            if (ent.bus_err)                 fault_now  = 1'b1;
            else if (is_wr && ent.wprot)     fault_now  = 1'b1;
            else if (is_wr && !ent.modified) rewalk_now = 1'b1;
        end
        inh_now = hit && ent.inhibit && !fault_now && !rewalk_now;
    end

    // Join the page field and the offset on the bus width
    assign pa_now   = hit ? ADDR_W'({ent.ppn, ofs}) : '0;
    assign drop_now = rewalk_now;

    // Register the response for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_paddr   <= '0;
            rsp_inhibit <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_rewalk  <= 1'b0;
        end else begin
            rsp_valid   <= req;
            rsp_hit     <= hit;
            rsp_paddr   <= pa_now;
            rsp_inhibit <= inh_now;
            rsp_fault   <= fault_now;
            rsp_rewalk  <= rewalk_now;
        end
    end

    // R4
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fault && rsp_rewalk));

    // R7
    inhibit_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_inhibit |-> (rsp_hit && !rsp_fault && !rsp_rewalk));

    // R6
    rewalk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rewalk |-> $past((kind == ACC_WRITE) || (kind == ACC_RMW)));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && $past(req)));
endmodule

// File: rtl/xlat_cache.sv
// Fully associative address translation cache with per-page access checks.
// Lookups compare {privilege, page} against every entry in one cycle and
// answer one cycle later. Fills come from an external walker; a fill whose
// tag is present overwrites in place. Assumes 4 KB pages.
module xlat_cache
    import xc_pkg::*;
#(
    parameter int unsigned ENTRIES = 22,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFS_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    input  logic [1:0]          lk_kind,
    input  logic                lk_super,
    input  logic                fl_valid,
    input  logic [ADDR_W-OFS_W-1:0] fl_lpn,
    input  logic                fl_super,
    input  logic [XC_PTE_W-1:0] fl_pte,
    input  logic                pg_inval,
    input  logic [ADDR_W-OFS_W-1:0] pg_lpn,
    input  logic                pg_super,
    input  logic                flush_all,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic                rsp_inhibit,
    output logic                rsp_fault,
    output logic                rsp_rewalk
);
    localparam int unsigned LPN_W = ADDR_W - OFS_W;
    localparam int unsigned TAG_W = LPN_W + 1;
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [TAG_W-1:0]   look_tag;
    logic [TAG_W-1:0]   maint_tag;
    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] maint_match;
    logic [ENTRIES-1:0] valid_vec;
    pte_t               look_data;
    logic [IDX_W-1:0]   hit_idx;
    logic               any_hit;
    logic [IDX_W-1:0]   same_idx;
    logic               exists;
    logic [IDX_W-1:0]   vic_idx;
    logic               fill_go;
    logic               alloc;
    logic               hit;
    logic               drop_now;
    logic [IDX_W-1:0]   wr_idx;

    // Build the lookup key and the maintenance key
    assign look_tag  = {lk_super, lk_addr[ADDR_W-1:OFS_W]};
    assign maint_tag = pg_inval ? {pg_super, pg_lpn} : {fl_super, fl_lpn};

    // Fills lose to same-cycle invalidates; reuse a matching slot
    assign fill_go = fl_valid && !pg_inval && !flush_all;
    assign alloc   = fill_go && !exists;
    assign wr_idx  = exists ? same_idx : vic_idx;
    assign hit     = lk_valid && any_hit;

    xc_tag_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .IDX_W   (IDX_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_tag    (look_tag),
        .maint_tag   (maint_tag),
        .wr_en       (fill_go),
        .wr_idx      (wr_idx),
        .wr_data     (pte_t'(fl_pte)),
        .drop_en     (drop_now),
        .drop_idx    (hit_idx),
        .kill_all    (flush_all),
        .kill_sel    (pg_inval),
        .look_match  (look_match),
        .maint_match (maint_match),
        .valid_vec   (valid_vec),
        .look_data   (look_data)
    );

    xc_oh_enc #(.N(ENTRIES), .W(IDX_W)) hit_enc_i (
        .oh  (look_match),
        .idx (hit_idx),
        .any (any_hit)
    );

    xc_oh_enc #(.N(ENTRIES), .W(IDX_W)) same_enc_i (
        .oh  (maint_match),
        .idx (same_idx),
        .any (exists)
    );

    xc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) victim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .alloc     (alloc),
        .vic_idx   (vic_idx)
    );

    xc_access_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) check_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (lk_valid),
        .kind        (lk_kind),
        .ofs         (lk_addr[OFS_W-1:0]),
        .hit         (hit),
        .ent         (look_data),
        .drop_now    (drop_now),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_paddr   (rsp_paddr),
        .rsp_inhibit (rsp_inhibit),
        .rsp_fault   (rsp_fault),
        .rsp_rewalk  (rsp_rewalk)
    );

    // R11
    fill_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && (pg_inval || flush_all)) |-> !fill_go);
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;
    localparam int N = 22;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic [1:0]  lk_kind;
    logic        lk_super;
    logic        fl_valid;
    logic [19:0] fl_lpn;
    logic        fl_super;
    logic [27:0] fl_pte;
    logic        pg_inval;
    logic [19:0] pg_lpn;
    logic        pg_super;
    logic        flush_all;
    logic        rsp_valid, rsp_hit, rsp_inhibit, rsp_fault, rsp_rewalk;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    logic        m_v   [N];
    logic [20:0] m_tag [N];
    logic [27:0] m_pte [N];
    int          m_ptr;

    always #10 clk = ~clk;

    xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_super(lk_super),
        .fl_valid(fl_valid), .fl_lpn(fl_lpn), .fl_super(fl_super), .fl_pte(fl_pte),
        .pg_inval(pg_inval), .pg_lpn(pg_lpn), .pg_super(pg_super), .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_inhibit(rsp_inhibit), .rsp_fault(rsp_fault), .rsp_rewalk(rsp_rewalk)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_addr = '0; lk_kind = 2'b00; lk_super = 0;
        fl_valid = 0; fl_lpn = '0; fl_super = 0; fl_pte = '0;
        pg_inval = 0; pg_lpn = '0; pg_super = 0; flush_all = 0;
    endtask

    function automatic int m_find(input logic [20:0] t);
        int r = -1;
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == t) r = i;
        return r;
    endfunction

    task automatic m_fill(input logic [19:0] lpn, input logic s, input logic [27:0] pte);
        int idx;
        idx = m_find({s, lpn});
        if (idx < 0) begin
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
            if (idx < 0) begin
                idx = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
        end
        m_v[idx] = 1'b1; m_tag[idx] = {s, lpn}; m_pte[idx] = pte;
    endtask

    task automatic m_inval(input logic [19:0] lpn, input logic s);
        int idx;
        idx = m_find({s, lpn});
        if (idx >= 0) m_v[idx] = 1'b0;
    endtask

    // Checks the response of a lookup issued in the cycle that just ended
    task automatic check_rsp(input string tg, input bit eh, input logic [27:0] p,
                             input logic [31:0] addr, input logic [1:0] kind);
        bit wr, ef, er, ei;
        logic [31:0] ea;
        wr = (kind == 2'b01) || (kind == 2'b10);
        ef = eh && (p[27] || (p[25] && wr));
        er = eh && wr && !p[27] && !p[25] && !p[24];
        ei = eh && p[26] && !ef && !er;
        ea = eh ? 32'({p[23:0], addr[11:0]}) : 32'h0;
        chk(rsp_valid == 1'b1, {tg, " R2 valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_hit == eh, {tg, " R2 hit"}, 64'(rsp_hit), 64'(eh));
        chk(rsp_paddr == ea, {tg, " R3 paddr"}, 64'(rsp_paddr), 64'(ea));
        chk(rsp_fault == ef, {tg, " R4 R5 fault"}, 64'(rsp_fault), 64'(ef));
        chk(rsp_rewalk == er, {tg, " R6 rewalk"}, 64'(rsp_rewalk), 64'(er));
        chk(rsp_inhibit == ei, {tg, " R7 inhibit"}, 64'(rsp_inhibit), 64'(ei));
    endtask

    task automatic do_lookup(input logic [31:0] addr, input logic [1:0] kind, input logic s, input string tg);
        int idx;
        logic [27:0] p;
        bit wr;
        idx = m_find({s, addr[31:12]});
        p = (idx >= 0) ? m_pte[idx] : 28'h0;
        wr = (kind == 2'b01) || (kind == 2'b10);
        lk_valid = 1; lk_addr = addr; lk_kind = kind; lk_super = s;
        @(negedge clk);
        lk_valid = 0;
        check_rsp(tg, idx >= 0, p, addr, kind);
        if (idx >= 0 && wr && !p[27] && !p[25] && !p[24]) m_v[idx] = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] lpn, input logic s, input logic [27:0] pte);
        fl_valid = 1; fl_lpn = lpn; fl_super = s; fl_pte = pte;
        m_fill(lpn, s, pte);
        @(negedge clk);
        fl_valid = 0;
        chk(rsp_valid == 1'b0, "R2 no lookup", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_inval(input logic [19:0] lpn, input logic s);
        pg_inval = 1; pg_lpn = lpn; pg_super = s;
        m_inval(lpn, s);
        @(negedge clk);
        pg_inval = 0;
    endtask

    task automatic do_flush();
        flush_all = 1;
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        @(negedge clk);
        flush_all = 0;
    endtask

    function automatic logic [27:0] mk_pte(bit b, bit ci, bit wp, bit m, logic [23:0] ppn);
        return {b, ci, wp, m, ppn};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1DE5));
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = '0; m_pte[i] = '0; end
        m_ptr = 0;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state of the outputs
        chk({rsp_valid, rsp_hit, rsp_fault, rsp_rewalk, rsp_inhibit} == 5'b0, "R1 flags", 64'({rsp_valid, rsp_hit, rsp_fault, rsp_rewalk, rsp_inhibit}), 64'd0);
        chk(rsp_paddr == 32'h0, "R1 paddr", 64'(rsp_paddr), 64'd0);
        rst_n = 1;
        do_lookup(32'h1234_5678, 2'b00, 1'b0, "R1 empty");

        // R3 R7 inhibit page, privilege is part of the tag
        do_fill(20'h00100, 1'b0, mk_pte(0, 1, 0, 1, 24'hABC123));
        do_lookup(32'h0010_0FED, 2'b00, 1'b0, "R7 ci read");
        do_lookup(32'h0010_0004, 2'b01, 1'b0, "R3 write ok");
        do_lookup(32'h0010_0004, 2'b00, 1'b1, "R2 other priv");

        // R4 bus-error entry faults every kind
        do_fill(20'h00200, 1'b1, mk_pte(1, 1, 1, 0, 24'h000200));
        do_lookup(32'h0020_0010, 2'b00, 1'b1, "R4 read");
        do_lookup(32'h0020_0010, 2'b01, 1'b1, "R4 write");
        do_lookup(32'h0020_0010, 2'b10, 1'b1, "R4 rmw");

        // R5 write protect with modified clear
        do_fill(20'h00300, 1'b0, mk_pte(0, 0, 1, 0, 24'h000777));
        do_lookup(32'h0030_0100, 2'b00, 1'b0, "R5 read");
        do_lookup(32'h0030_0100, 2'b11, 1'b0, "R5 kind11 read");
        do_lookup(32'h0030_0100, 2'b01, 1'b0, "R5 write");
        do_lookup(32'h0030_0100, 2'b10, 1'b0, "R5 rmw");

        // R6 first write aborts, entry dropped, refill then write completes
        do_fill(20'h00400, 1'b0, mk_pte(0, 1, 0, 0, 24'h004400));
        do_lookup(32'h0040_0020, 2'b00, 1'b0, "R6 read");
        do_lookup(32'h0040_0020, 2'b01, 1'b0, "R6 write");
        do_lookup(32'h0040_0020, 2'b00, 1'b0, "R6 dropped");
        do_fill(20'h00400, 1'b0, mk_pte(0, 1, 0, 1, 24'h004400));
        do_lookup(32'h0040_0020, 2'b01, 1'b0, "R6 retry");

        // R8 overwrite in place
        do_fill(20'h00100, 1'b0, mk_pte(0, 0, 0, 1, 24'h55AA55));
        do_lookup(32'h0010_0ABC, 2'b00, 1'b0, "R8 reload");

        // R10 flush all, then R9 replacement order
        do_flush();
        do_lookup(32'h0010_0ABC, 2'b00, 1'b0, "R10 flushed");
        for (int i = 0; i < N + 2; i++) do_fill(20'(32'h01000 + i), 1'b0, mk_pte(0, 0, 0, 1, 24'(i)));
        do_lookup(32'h0100_0000, 2'b00, 1'b0, "R9 evicted0");
        do_lookup(32'h0100_1000, 2'b00, 1'b0, "R9 evicted1");
        do_lookup(32'h0100_2000, 2'b00, 1'b0, "R9 kept2");
        do_inval(20'h01005, 1'b0);
        do_lookup(32'h0100_5000, 2'b00, 1'b0, "R10 inval");
        do_lookup(32'h0100_6000, 2'b00, 1'b0, "R10 neighbour");
        do_fill(20'h02000, 1'b0, mk_pte(0, 0, 0, 1, 24'h2000));
        do_lookup(32'h0100_2000, 2'b00, 1'b0, "R9 free first");
        do_lookup(32'h0200_0000, 2'b00, 1'b0, "R9 new");

        // R11 fill dropped when invalidate arrives in the same cycle
        fl_valid = 1; fl_lpn = 20'h03000; fl_super = 0; fl_pte = mk_pte(0, 0, 0, 1, 24'h3);
        pg_inval = 1; pg_lpn = 20'h01006; pg_super = 0;
        m_inval(20'h01006, 1'b0);
        @(negedge clk);
        idle_inputs();
        do_lookup(32'h0300_0000, 2'b00, 1'b0, "R11 fill lost");
        do_lookup(32'h0100_6000, 2'b00, 1'b0, "R11 inval won");
        // R11 lookup sees contents before the edge
        begin
            int idx;
            logic [27:0] p;
            idx = m_find({1'b0, 20'h01007});
            p = m_pte[idx];
            lk_valid = 1; lk_addr = 32'h0100_7008; lk_kind = 2'b00; lk_super = 0;
            pg_inval = 1; pg_lpn = 20'h01007; pg_super = 0;
            m_inval(20'h01007, 1'b0);
            @(negedge clk);
            idle_inputs();
            check_rsp("R11 same cycle", idx >= 0, p, 32'h0100_7008, 2'b00);
        end
        // R11 flush beats fill
        fl_valid = 1; fl_lpn = 20'h03001; fl_super = 1; fl_pte = mk_pte(0, 0, 0, 1, 24'h9);
        flush_all = 1;
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        @(negedge clk);
        idle_inputs();
        do_lookup(32'h0300_1000, 2'b00, 1'b1, "R11 flush wins");

        // Random mix against the model
        for (int it = 0; it < 6000; it++) begin
            int unsigned r;
            logic [19:0] lpn;
            logic s;
            r = $urandom_range(99);
            lpn = 20'(32'h00500 + $urandom_range(39) * 3);
            s = 1'($urandom_range(1));
            if (r < 35) begin
                do_fill(lpn, s, mk_pte($urandom_range(7) == 0, 1'($urandom_range(1)),
                                       $urandom_range(3) == 0, 1'($urandom_range(1)),
                                       24'($urandom)));
            end else if (r < 92) begin
                do_lookup({lpn, 12'($urandom)}, 2'($urandom_range(3)), s, "rand");
            end else if (r < 99) begin
                do_inval(lpn, s);
            end else begin
                do_flush();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule